// File: doc/BRIEF.md
# Single-Operand Register ALU

This block performs the one-operand register operations of a 16-bit processor datapath: step up by one, step down by one, clear, bitwise complement, arithmetic shifts in both directions and rotations in both directions that pass through the link (carry) flag. A size select chooses between operating on the whole word or on the low byte alone. In byte mode the upper byte of the register is written back exactly as it came in.

The surrounding core supplies a 3-bit operation code, the size select, the current register value and the current link flag. One clock later the block presents the value to write back, the new link and the zero and minus flags. The zero and minus flags cover only the active width. Register file access and instruction decode stay in the core.

Top module: `unary_alu`

## Requirements
- R1: Operation code 0 adds one to the active field; link_o is 1 exactly when the field wraps from all ones to zero.
- R2: Operation code 1 subtracts one from the active field; link_o is 1 exactly when the field was zero before the operation (a borrow).
- R3: Operation code 2 makes the active field zero and returns link_i unchanged on link_o.
- R4: Operation code 3 complements every bit of the active field and returns link_i unchanged on link_o.
- R5: Operation code 4 shifts the active field right by one and keeps its top (sign) bit; the bit shifted out of bit 0 goes to link_o.
- R6: Operation code 5 shifts the active field left by one and fills bit 0 with zero; the old top bit of the field goes to link_o.
- R7: Operation code 6 rotates right through link: link_i enters the top bit of the field and bit 0 of the field goes to link_o. This is a 9-bit rotation in byte mode and a 17-bit rotation in word mode.
- R8: Operation code 7 rotates left through link: link_i enters bit 0 and the top bit of the field goes to link_o.
- R9: With byte_i = 1 the active field is bits 7:0, and res_o[15:8] equals val_i[15:8]. With byte_i = 0 the field is all 16 bits.
- R10: zero_o is 1 exactly when the active field of res_o is all zeros. Bits outside the active field do not affect it.
- R11: minus_o equals the top bit of the active field of res_o (bit 7 in byte mode, bit 15 in word mode).
- R12: Outputs are registered. The result for the inputs present at a rising clock edge appears after that edge, and while rst_n is low all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Operation code 0..7 |
| byte_i | input | 1 | 1 = low byte only, 0 = full word |
| val_i | input | 16 | Register value in |
| link_i | input | 1 | Current link/carry flag |
| res_o | output | 16 | Register value to write back |
| link_o | output | 1 | New link/carry flag |
| zero_o | output | 1 | Active field of result is zero |
| minus_o | output | 1 | Top bit of active field of result |

## Verification
In byte mode the bench sweeps every low-byte value under every operation and both link values, with varied upper bytes. A design that took its carry, sign or flags from bit 15 instead of bit 7 would give wrong link, minus or zero results in that sweep. A design that let byte-mode results spill into the upper byte would also fail the sweep, because the upper byte would not match what came in. The boundary values 0x00/0xFF, 0x7F/0x80 and their 16-bit counterparts catch wrap and borrow carries that are wrong or missing. Running the rotations with both link values shows whether link truly takes part in the rotation, or whether the design only rotates the register. Clear and complement with link set show whether link is disturbed when it should be left alone.

// File: rtl/unary_alu_pkg.sv
package unary_alu_pkg;

   typedef enum logic [2:0] {
      UOP_INC = 3'd0,
      UOP_DEC = 3'd1,
      UOP_CLR = 3'd2,
      UOP_INV = 3'd3,
      UOP_ASR = 3'd4,
      UOP_ASL = 3'd5,
      UOP_RRC = 3'd6,
      UOP_RLC = 3'd7
   } uop_e;

   typedef struct packed {
      logic link;
      logic zero;
      logic minus;
   } uflags_t;

endpackage

// File: rtl/uop_lane.sv
// Computes one operation over a field of W bits, with carry in and carry out.
module uop_lane
   import unary_alu_pkg::*;
#(
   parameter int W = 8
) (
   input  uop_e         op,
   input  logic [W-1:0] a,
   input  logic         cin,
   output logic [W-1:0] r,
   output logic         cout
);

   localparam int TOP = W - 1;

   if (W < 2) begin : g_w_chk
      $error("uop_lane: W must be at least 2");
   end

   logic [W:0] inc_ext;
   logic [W:0] dec_ext;

   assign inc_ext = {1'b0, a} + {{W{1'b0}}, 1'b1};
   assign dec_ext = {1'b0, a} - {{W{1'b0}}, 1'b1};

   always_comb begin
      r    = a;
      cout = cin;
      unique case (op)
         UOP_INC: begin
            r    = inc_ext[W-1:0];
            cout = inc_ext[W];
         end
         UOP_DEC: begin
            r    = dec_ext[W-1:0];
            cout = dec_ext[W];
         end
         UOP_CLR: begin
            r    = '0;
            cout = cin;
         end
         UOP_INV: begin
            r    = ~a;
            cout = cin;
         end
         UOP_ASR: begin
            r    = {a[TOP], a[TOP:1]};
            cout = a[0];
         end
         UOP_ASL: begin
            r    = {a[TOP-1:0], 1'b0};
            cout = a[TOP];
         end
         UOP_RRC: begin
            r    = {cin, a[TOP:1]};
            cout = a[0];
         end
         UOP_RLC: begin
            r    = {a[TOP-1:0], cin};
            cout = a[TOP];
         end
         default: begin
            r    = a;
            cout = cin;
         end
      endcase
   end

endmodule

// File: rtl/uop_flags.sv
// Zero and minus over the active width chosen by the size select.
module uop_flags #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              byte_sel,
   input  logic [DATA_W-1:0] r,
   output logic              zero,
   output logic              minus
);

   logic byte_zero;
   logic word_zero;

   assign byte_zero = (r[BYTE_W-1:0] == '0);
   assign word_zero = (r == '0);

   always_comb begin
      if (byte_sel) begin
         zero  = byte_zero;
         minus = r[BYTE_W-1];
      end else begin
         zero  = word_zero;
         minus = r[DATA_W-1];
      end
   end

endmodule

// File: rtl/unary_alu.sv
module unary_alu
   import unary_alu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        op_i,
   input  logic              byte_i,
   input  logic [DATA_W-1:0] val_i,
   input  logic              link_i,
   output logic [DATA_W-1:0] res_o,
   output logic              link_o,
   output logic              zero_o,
   output logic              minus_o
);

   localparam int HI_W = DATA_W - BYTE_W;

   if (BYTE_W < 2 || BYTE_W >= DATA_W) begin : g_size_chk
      $error("unary_alu: need 2 <= BYTE_W < DATA_W");
   end

   uop_e              op;
   logic [BYTE_W-1:0] byte_r;
   logic              byte_c;
   logic [DATA_W-1:0] word_r;
   logic              word_c;
   logic [DATA_W-1:0] res_n;
   uflags_t           flg_n;
   logic              z_n;
   logic              m_n;

   assign op = uop_e'(op_i);

   uop_lane #(.W(BYTE_W)) u_byte_lane (
      .op   (op),
      .a    (val_i[BYTE_W-1:0]),
      .cin  (link_i),
      .r    (byte_r),
      .cout (byte_c)
   );

   uop_lane #(.W(DATA_W)) u_word_lane (
      .op   (op),
      .a    (val_i),
      .cin  (link_i),
      .r    (word_r),
      .cout (word_c)
   );

   always_comb begin
      if (byte_i) res_n = {val_i[DATA_W-1:DATA_W-HI_W], byte_r};
      else        res_n = word_r;
   end

   uop_flags #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_flags (
      .byte_sel (byte_i),
      .r        (res_n),
      .zero     (z_n),
      .minus    (m_n)
   );

   assign flg_n.link  = byte_i ? byte_c : word_c;
   assign flg_n.zero  = z_n;
   assign flg_n.minus = m_n;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_o   <= '0;
         link_o  <= 1'b0;
         zero_o  <= 1'b0;
         minus_o <= 1'b0;
      end else begin
         res_o   <= res_n;
         link_o  <= flg_n.link;
         zero_o  <= flg_n.zero;
         minus_o <= flg_n.minus;
      end
   end

endmodule

// File: rtl/unary_alu_chk.sv
module unary_alu_chk #(
   parameter int DATA_W = 16,
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        op_i,
   input logic              byte_i,
   input logic [DATA_W-1:0] val_i,
   input logic              link_i,
   input logic [DATA_W-1:0] res_o,
   input logic              link_o,
   input logic              zero_o,
   input logic              minus_o
);

   logic primed;
   always_ff @(posedge clk) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R3
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(op_i) == 3'd2 && !$past(byte_i)) |-> (res_o == '0 && zero_o && link_o == $past(link_i)));

   // R4
   invert_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(op_i) == 3'd3) |-> (link_o == $past(link_i)));

   // R7
   rot_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(op_i) == 3'd6) |-> (link_o == $past(val_i[0])));

   // R9
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(byte_i)) |-> (res_o[DATA_W-1:BYTE_W] == $past(val_i[DATA_W-1:BYTE_W])));

   // R10
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (zero_o == ($past(byte_i) ? (res_o[BYTE_W-1:0] == '0) : (res_o == '0))));

   // R11
   minus_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> (minus_o == ($past(byte_i) ? res_o[BYTE_W-1] : res_o[DATA_W-1])));

   // R12
   reset_out_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> (res_o == '0 && !link_o && !zero_o && !minus_o));

endmodule

bind unary_alu unary_alu_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .op_i    (op_i),
   .byte_i  (byte_i),
   .val_i   (val_i),
   .link_i  (link_i),
   .res_o   (res_o),
   .link_o  (link_o),
   .zero_o  (zero_o),
   .minus_o (minus_o)
);

// File: tb/sim_unary_alu.sv
`timescale 1ns/1ps
module sim_unary_alu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  op_i = 3'd0;
   logic        byte_i = 1'b0;
   logic [15:0] val_i = 16'h0;
   logic        link_i = 1'b0;
   logic [15:0] res_o;
   logic        link_o, zero_o, minus_o;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   unary_alu u0 (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .byte_i(byte_i),
      .val_i(val_i), .link_i(link_i), .res_o(res_o),
      .link_o(link_o), .zero_o(zero_o), .minus_o(minus_o)
   );

   function automatic string op_tag(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4: return "R5";
         5: return "R6";
         6: return "R7";
         default: return "R8";
      endcase
   endfunction

   // Expected result word and flags from arithmetic on the active field.
   task automatic model(input int op, input bit bsel, input int val, input bit lin,
                        output int e_res, output bit e_l, output bit e_z, output bit e_m);
      int n, mask, half, a, r, s;
      bit l;
      n    = bsel ? 8 : 16;
      mask = (1 << n) - 1;
      half = 1 << (n - 1);
      a    = val & mask;
      l    = lin;
      r    = a;
      case (op)
         0: begin s = a + 1; r = s & mask; l = (s > mask); end
         1: begin r = (a + mask) & mask; l = (a == 0); end
         2: begin r = 0; end
         3: begin r = mask - a; end
         4: begin r = a / 2 + ((a >= half) ? half : 0); l = a[0]; end
         5: begin r = (a * 2) & mask; l = (a >= half); end
         6: begin r = a / 2 + (lin ? half : 0); l = a[0]; end
         default: begin r = (a * 2 + int'(lin)) & mask; l = (a >= half); end
      endcase
      e_res = bsel ? ((val & 16'hFF00) | r) : r;
      e_l = l;
      e_z = (r == 0);
      e_m = (r >= half);
   endtask

   task automatic apply_and_check(input int op, input bit bsel, input int val, input bit lin);
      int e_res;
      bit e_l, e_z, e_m;
      @(negedge clk);
      op_i = op[2:0]; byte_i = bsel; val_i = val[15:0]; link_i = lin;
      model(op, bsel, val, lin, e_res, e_l, e_z, e_m);
      @(posedge clk);
      @(negedge clk);
      checks++;
      if (res_o !== e_res[15:0] || link_o !== e_l) begin
         errors++;
         $display("FAIL %s op=%0d byte=%0d val=%h lin=%0d: res/link %h/%0d expected %h/%0d",
                  op_tag(op), op, bsel, val[15:0], lin, res_o, link_o, e_res[15:0], e_l);
      end
      if (bsel && res_o[15:8] !== val[15:8]) begin
         errors++;
         $display("FAIL R9 upper byte %h expected %h", res_o[15:8], val[15:8]);
      end
      if (zero_o !== e_z) begin
         errors++;
         $display("FAIL R10 zero %0d expected %0d (op=%0d byte=%0d val=%h)", zero_o, e_z, op, bsel, val[15:0]);
      end
      if (minus_o !== e_m) begin
         errors++;
         $display("FAIL R11 minus %0d expected %0d (op=%0d byte=%0d val=%h)", minus_o, e_m, op, bsel, val[15:0]);
      end
   endtask

   task automatic check_reset();
      checks++;
      if (res_o !== 16'h0 || link_o !== 1'b0 || zero_o !== 1'b0 || minus_o !== 1'b0) begin
         errors++;
         $display("FAIL R12 reset outputs %h %0d %0d %0d expected 0000 0 0 0",
                  res_o, link_o, zero_o, minus_o);
      end
   endtask

   function automatic int word_val(input int i);
      case (i)
         0: return 16'h0000;
         1: return 16'hFFFF;
         2: return 16'h7FFF;
         3: return 16'h8000;
         4: return 16'h0001;
         5: return 16'h00FF;
         6: return 16'h0100;
         7: return 16'h8001;
         default: return (i * 16'h9E37 + 16'h1234) & 16'hFFFF;
      endcase
   endfunction

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_reset();                      // R12 reset state
      rst_n = 1'b1;
      // byte mode: every low byte, all ops, both links (R1..R11)
      for (int op = 0; op < 8; op++)
         for (int l = 0; l < 2; l++)
            for (int v = 0; v < 256; v++)
               apply_and_check(op, 1'b1, ((v * 37 + op * 91 + 16'h5A) & 16'hFF) << 8 | v, l[0]);
      // word mode: corner values plus a spread (R1..R8, R10, R11)
      for (int op = 0; op < 8; op++)
         for (int l = 0; l < 2; l++)
            for (int i = 0; i < 200; i++)
               apply_and_check(op, 1'b0, word_val(i), l[0]);
      // R12: reset mid-run clears outputs
      apply_and_check(3, 1'b0, 16'h0F0F, 1'b1);
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check_reset();
      rst_n = 1'b1;
      // R12: one-cycle latency after reset
      apply_and_check(0, 1'b0, 16'hFFFF, 1'b0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog expired at %0d cycles", cycles);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule